// File: doc/BRIEF.md
# Dual-Issue Warp Issue Selector

This block is one scheduling partition of a multiprocessor core. It watches a fixed set of resident warp contexts, 16 by default, and in every cycle picks at most one warp to issue from. From that warp it can send the next instruction alone. It can also send the next two instructions together when they form an independent arithmetic/memory pair. Transcendental operations (sine, cosine, reciprocal, reciprocal square root) go to a separate special-function port and never take an arithmetic or memory slot.

For each warp the surrounding core supplies a ready flag, a stall flag (set while the warp waits on a long-latency event), the class of its next two instructions, a flag saying the second instruction exists, and a flag saying the second does not depend on the first. The block drives one valid strobe per execution port. It also reports which warp issued and how many of its instructions were consumed, so the instruction buffer can advance. The outputs are combinational within the cycle. Only the round-robin position is registered.

Top module: `warp_issue_sched`

## Requirements
- R1: Each cycle at most one warp issues. All asserted port strobes belong to the warp on `issue_warp`, and `issue_count` equals the number of asserted port strobes.
- R2: A warp may be picked only when its ready flag is 1, its stall flag is 0, and the port for its first instruction has its ready input at 1. A stalled warp is passed over in favour of the next qualifying warp.
- R3: The search starts at the warp after the one that issued last and wraps from N-1 to 0. After reset it starts at warp 0.
- R4: Both instructions issue (`issue_count` = 2, `alu_valid` and `mem_valid` both 1) only when all of these hold: the second instruction is present, it is independent, one instruction has class 2'b00 (arithmetic) and the other has class 2'b01 (memory), in either order, and the port of the second instruction is ready.
- R5: If the second instruction depends on the first, or both have the same class, only the first issues (`issue_count` = 1).
- R6: Class codes 2'b10 and 2'b11 are special-function operations. They raise only `sfu_valid` and never pair with another instruction, either as first or as second.
- R7: When no warp qualifies, `issue_valid`, `alu_valid`, `mem_valid` and `sfu_valid` are all 0 and `issue_count` is 0.
- R8: An instruction issues only to a port whose ready input is 1. If the second instruction's port is not ready, the warp issues its first instruction alone.
- R9: A cycle without an issue leaves the round-robin position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | N | Per-warp ready flag |
| warp_stall | input | N | Per-warp long-latency stall flag |
| inst0_cls | input | 2*N | Class of each warp's next instruction (bits 2w+1:2w) |
| inst1_cls | input | 2*N | Class of each warp's instruction after that |
| inst1_valid | input | N | Second instruction present |
| inst1_indep | input | N | Second instruction independent of the first |
| alu_rdy | input | 1 | Arithmetic port can accept |
| mem_rdy | input | 1 | Memory port can accept |
| sfu_rdy | input | 1 | Special-function port can accept |
| issue_valid | output | 1 | A warp issued this cycle |
| issue_warp | output | log2(N) | Index of the issuing warp |
| issue_count | output | 2 | Instructions consumed from that warp (0, 1 or 2) |
| alu_valid | output | 1 | Instruction sent to arithmetic port |
| mem_valid | output | 1 | Instruction sent to memory port |
| sfu_valid | output | 1 | Instruction sent to special-function port |

## Verification
The only hidden state is the last-issued warp index. If it is wrong, the next issuing cycle reports the wrong `issue_warp`, so each issuing cycle that follows an earlier issue checks the pointer, and the error shows within one cycle. Errors in the pairing or port-readiness logic show in the same cycle as a wrong `issue_count`, or as a strobe raised on the wrong port. Because the picked warp selects which class fields are decoded, a picking error also shows up as wrong port strobes.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef enum logic [1:0] {
    CLS_ALU  = 2'b00,
    CLS_MEM  = 2'b01,
    CLS_SFU  = 2'b10,
    CLS_SFU2 = 2'b11
  } inst_cls_e;

  function automatic logic is_special(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic port_free(input logic [1:0] c, input logic a_rdy,
                                     input logic m_rdy, input logic s_rdy);
    logic r;
    unique case (c)
      CLS_ALU: r = a_rdy;
      CLS_MEM: r = m_rdy;
      default: r = s_rdy;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ws_pair_check.sv
module ws_pair_check
  import ws_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [2*N-1:0] inst0_cls,
  input  logic [2*N-1:0] inst1_cls,
  input  logic [N-1:0]   inst1_valid,
  input  logic [N-1:0]   inst1_indep,
  input  logic           alu_rdy,
  input  logic           mem_rdy,
  input  logic           sfu_rdy,
  output logic [N-1:0]   first_ok,
  output logic [N-1:0]   pair_ok
);

  for (genvar w = 0; w < N; w++) begin : g_warp
    logic [1:0] c0;
    logic [1:0] c1;
    logic       mix;

    assign c0  = inst0_cls[2*w +: 2];
    assign c1  = inst1_cls[2*w +: 2];
    // Only an arithmetic/memory pair in either order may share a cycle
    assign mix = ((c0 == CLS_ALU) && (c1 == CLS_MEM)) ||
                 ((c0 == CLS_MEM) && (c1 == CLS_ALU));

    assign first_ok[w] = port_free(c0, alu_rdy, mem_rdy, sfu_rdy);
    assign pair_ok[w]  = inst1_valid[w] && inst1_indep[w] && mix &&
                         port_free(c1, alu_rdy, mem_rdy, sfu_rdy);
  end

endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (int'(last) + i) % N;
      if (!found && req[k]) begin
        found = 1'b1;
        pick  = IW'(k);
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import ws_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  warp_ready,
  input  logic [N-1:0]  warp_stall,
  input  logic [2*N-1:0] inst0_cls,
  input  logic [2*N-1:0] inst1_cls,
  input  logic [N-1:0]  inst1_valid,
  input  logic [N-1:0]  inst1_indep,
  input  logic          alu_rdy,
  input  logic          mem_rdy,
  input  logic          sfu_rdy,
  output logic          issue_valid,
  output logic [IW-1:0] issue_warp,
  output logic [1:0]    issue_count,
  output logic          alu_valid,
  output logic          mem_valid,
  output logic          sfu_valid
);

  localparam logic [IW-1:0] LAST_INIT = IW'(N - 1);

  logic [N-1:0]  first_ok;
  logic [N-1:0]  pair_ok;
  logic [N-1:0]  eligible;
  logic          found;
  logic [IW-1:0] pick;
  logic [IW-1:0] last_q;
  logic [IW-1:0] last_d;
  logic          last_en;
  logic [1:0]    sel_cls;
  logic          dual;

  ws_pair_check #(.N(N)) pair_i (
    .inst0_cls  (inst0_cls),
    .inst1_cls  (inst1_cls),
    .inst1_valid(inst1_valid),
    .inst1_indep(inst1_indep),
    .alu_rdy    (alu_rdy),
    .mem_rdy    (mem_rdy),
    .sfu_rdy    (sfu_rdy),
    .first_ok   (first_ok),
    .pair_ok    (pair_ok)
  );

  assign eligible = warp_ready & ~warp_stall & first_ok;

  ws_rr_pick #(.N(N), .IW(IW)) pick_i (
    .req  (eligible),
    .last (last_q),
    .found(found),
    .pick (pick)
  );

  // Output decode for the single picked warp
  always_comb begin
    sel_cls     = inst0_cls[2*pick +: 2];
    dual        = found && pair_ok[pick];
    issue_valid = found;
    issue_warp  = pick;
    alu_valid   = found && ((sel_cls == CLS_ALU) || dual);
    mem_valid   = found && ((sel_cls == CLS_MEM) || dual);
    sfu_valid   = found && is_special(sel_cls);
    issue_count = !found ? 2'd0 : (dual ? 2'd2 : 2'd1);
  end

  // Round-robin position: next-state
  always_comb begin
    last_en = found;
    last_d  = pick;
  end

  // Round-robin position: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LAST_INIT;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/ws_sched_checker.sv
module ws_sched_checker #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  warp_ready,
  input logic [N-1:0]  warp_stall,
  input logic          alu_rdy,
  input logic          mem_rdy,
  input logic          sfu_rdy,
  input logic          issue_valid,
  input logic [IW-1:0] issue_warp,
  input logic [1:0]    issue_count,
  input logic          alu_valid,
  input logic          mem_valid,
  input logic          sfu_valid
);

  a_r1_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_count) == $countones({alu_valid, mem_valid, sfu_valid}));

  a_r1_strobe_needs_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid || mem_valid || sfu_valid) |-> issue_valid);

  a_r2_pick_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (warp_ready[issue_warp] && !warp_stall[issue_warp]));

  a_r6_special_alone: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_valid |-> (!alu_valid && !mem_valid));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((warp_ready & ~warp_stall) == '0) |->
      (!issue_valid && !alu_valid && !mem_valid && !sfu_valid));

  a_r8_alu_port_ready: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |-> alu_rdy);

  a_r8_mem_port_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_rdy);

  a_r8_sfu_port_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_valid |-> sfu_rdy);

endmodule

bind warp_issue_sched ws_sched_checker #(.N(N), .IW(IW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .warp_ready (warp_ready),
  .warp_stall (warp_stall),
  .alu_rdy    (alu_rdy),
  .mem_rdy    (mem_rdy),
  .sfu_rdy    (sfu_rdy),
  .issue_valid(issue_valid),
  .issue_warp (issue_warp),
  .issue_count(issue_count),
  .alu_valid  (alu_valid),
  .mem_valid  (mem_valid),
  .sfu_valid  (sfu_valid)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;

  localparam int N  = 16;
  localparam int IW = 4;

  typedef struct {
    logic          v;
    logic [IW-1:0] w;
    logic [1:0]    cnt;
    logic          a;
    logic          m;
    logic          s;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  warp_ready;
  logic [N-1:0]  warp_stall;
  logic [2*N-1:0] inst0_cls;
  logic [2*N-1:0] inst1_cls;
  logic [N-1:0]  inst1_valid;
  logic [N-1:0]  inst1_indep;
  logic          alu_rdy;
  logic          mem_rdy;
  logic          sfu_rdy;
  logic          issue_valid;
  logic [IW-1:0] issue_warp;
  logic [1:0]    issue_count;
  logic          alu_valid;
  logic          mem_valid;
  logic          sfu_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int model_last = N - 1;
  bit finished = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  warp_issue_sched #(.N(N), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .warp_ready(warp_ready), .warp_stall(warp_stall),
    .inst0_cls(inst0_cls), .inst1_cls(inst1_cls),
    .inst1_valid(inst1_valid), .inst1_indep(inst1_indep),
    .alu_rdy(alu_rdy), .mem_rdy(mem_rdy), .sfu_rdy(sfu_rdy),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_count(issue_count),
    .alu_valid(alu_valid), .mem_valid(mem_valid), .sfu_valid(sfu_valid)
  );

  function automatic logic rdy_for(input logic [1:0] c);
    if (c == 2'b00) return alu_rdy;
    if (c == 2'b01) return mem_rdy;
    return sfu_rdy;
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input string tag);
    exp_t e;
    e.v = 0; e.w = '0; e.cnt = 0; e.a = 0; e.m = 0; e.s = 0; e.tag = tag;
    for (int i = 1; i <= N; i++) begin
      int k;
      logic [1:0] c0, c1;
      logic pair;
      k  = (model_last + i) % N;
      c0 = inst0_cls[2*k +: 2];
      c1 = inst1_cls[2*k +: 2];
      if (!e.v && warp_ready[k] && !warp_stall[k] && rdy_for(c0)) begin
        pair = inst1_valid[k] && inst1_indep[k] &&
               ((c0 == 2'b00 && c1 == 2'b01) || (c0 == 2'b01 && c1 == 2'b00)) &&
               rdy_for(c1);
        e.v   = 1;
        e.w   = IW'(k);
        e.cnt = pair ? 2'd2 : 2'd1;
        e.a   = (c0 == 2'b00) || pair;
        e.m   = (c0 == 2'b01) || pair;
        e.s   = c0[1];
      end
    end
    return e;
  endfunction

  // Driver side: inputs already set after a falling edge; push expectation
  task automatic step(input string tag);
    exp_t e;
    e = model(tag);
    q.push_back(e);
    if (e.v) model_last = int'(e.w);
    @(negedge clk);
  endtask

  task automatic fill(input logic [1:0] c0, input logic [1:0] c1,
                      input logic v1, input logic ind);
    for (int w = 0; w < N; w++) begin
      inst0_cls[2*w +: 2] = c0;
      inst1_cls[2*w +: 2] = c1;
    end
    inst1_valid = {N{v1}};
    inst1_indep = {N{ind}};
  endtask

  // Monitor side: compare mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (issue_valid !== e.v || (e.v && issue_warp !== e.w) ||
            issue_count !== e.cnt || alu_valid !== e.a ||
            mem_valid !== e.m || sfu_valid !== e.s) begin
          n_fail++;
          $display("FAIL %s: got v=%b w=%0d cnt=%0d a/m/s=%b%b%b exp v=%b w=%0d cnt=%0d a/m/s=%b%b%b",
                   e.tag, issue_valid, issue_warp, issue_count, alu_valid,
                   mem_valid, sfu_valid, e.v, e.w, e.cnt, e.a, e.m, e.s);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    warp_ready = '0; warp_stall = '0;
    fill(2'b00, 2'b00, 0, 0);
    alu_rdy = 1; mem_rdy = 1; sfu_rdy = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R7: nothing ready -> quiet, after reset
    step("R7 idle after reset");
    // R3: reset start at warp 0, then 1, 2
    warp_ready = '1;
    step("R3 first pick warp 0");
    step("R3 rotate to 1");
    step("R3 rotate to 2");
    // R2: stalled warps 3..7 passed over
    warp_stall = 16'h00F8;
    step("R2 skip stalled");
    warp_stall = '0;
    // R9: idle cycle keeps pointer, then resume at 9
    warp_ready = '0;
    step("R9 idle hold");
    warp_ready = '1;
    step("R9 resume after idle");
    // R4: independent ALU+MEM pair, both orders
    fill(2'b00, 2'b01, 1, 1);
    step("R4 alu+mem pair");
    fill(2'b01, 2'b00, 1, 1);
    step("R4 mem+alu pair");
    // R5: dependent, and same class
    fill(2'b00, 2'b01, 1, 0);
    step("R5 dependent single");
    fill(2'b01, 2'b01, 1, 1);
    step("R5 same class single");
    // R6: special first, special second
    fill(2'b10, 2'b00, 1, 1);
    step("R6 special first");
    fill(2'b11, 2'b01, 1, 1);
    step("R6 special alt code");
    fill(2'b00, 2'b10, 1, 1);
    step("R6 special second unpaired");
    // R8: second port busy -> single; first port busy -> warp skipped
    fill(2'b00, 2'b01, 1, 1);
    mem_rdy = 0;
    step("R8 second port busy");
    mem_rdy = 1;
    for (int w = 0; w < N; w++) inst0_cls[2*w +: 2] = (w % 2 == 0) ? 2'b00 : 2'b01;
    alu_rdy = 0;
    step("R8 first port busy skips warp");
    step("R8 first port busy again");
    alu_rdy = 1;
    // R7: all stalled
    warp_stall = '1;
    step("R7 all stalled");
    warp_stall = '0;
    // R1/R2/R4/R5/R6/R8: mixed random patterns
    for (int t = 0; t < 400; t++) begin
      warp_ready  = N'($urandom);
      warp_stall  = N'($urandom & $urandom);
      inst0_cls   = 32'($urandom);
      inst1_cls   = 32'($urandom);
      inst1_valid = N'($urandom);
      inst1_indep = N'($urandom);
      alu_rdy = ($urandom % 4) != 0;
      mem_rdy = ($urandom % 4) != 0;
      sfu_rdy = ($urandom % 4) != 0;
      step("R1/R2/R3/R4/R5/R6/R8 random");
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule